// File: doc/BRIEF.md
# Bloom Array Rebuild Scheduler

A shared cache that sits behind one Bloom-style hit/miss predictor per set cannot always clear a saturated counter when a line leaves that set. Once an array has collected enough of these failed decrements, the logic around it raises a rebuild request for that array. This block collects those requests and later hands the arrays back for rebuild, one at a time. Requests go into a small FIFO. Each array index appears in the FIFO at most once. The head of the FIFO is released each time a programmable number of cache accesses has been counted.

A request can arrive while the FIFO is full. In that case it is not lost: the block sets a pending bit for that array. The next cache access to that set enqueues the array as soon as there is room, and the pending bit is then cleared. Only accesses count toward the issue period, not clock cycles. Accesses are counted only while issue is enabled and something is queued. Clearing the enable stops issue, but requests are still accepted and parked.

Top module: `bloom_rebuild_sched`

## Requirements
- R1: After reset the FIFO is empty (count 0, empty high, full low), no pending bit is set and no issue strobe is asserted.
- R2: A request for an array that is not queued, arriving while the FIFO holds fewer than QUEUE_DEPTH entries, is enqueued at the tail. The count rises by one on the next cycle.
- R3: A request for an array already held in the FIFO is ignored. The count and the pending bits do not change.
- R4: A request that arrives while the FIFO is full sets the pending bit of that array, at position equal to the array index in pending_o, and leaves the count unchanged. An array is never both pending and queued.
- R5: An access whose set index has its pending bit set enqueues that array, provided the FIFO is not full and no request is enqueued in the same cycle. The pending bit clears on the next cycle.
- R6: If a new request is enqueued in the same cycle as an access to a different pending array, the request takes the slot and the pending bit stays set.
- R7: An access is counted when enable is high and the FIFO is non-empty. The access that brings the count to the period pops the head, pulses issue_valid_o on the next cycle with the popped index, and restarts the count at zero. Arrays leave in arrival order.
- R8: A period of 0 or 1 makes every counted access issue.
- R9: While enable is low, no issue occurs, the access count holds, and requests are still enqueued or parked.
- R10: Once an array has been issued it can be requested and enqueued again.
- R11: queue_full_o is high exactly when the count equals QUEUE_DEPTH, and queue_empty_o exactly when it is zero. The count never exceeds QUEUE_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Allows rebuild issue and access counting |
| period_i | input | PERIOD_W | Counted accesses per issue (0 treated as 1) |
| req_valid_i | input | 1 | Rebuild request strobe |
| req_idx_i | input | IDX_W | Array index of the request |
| acc_valid_i | input | 1 | Cache access strobe |
| acc_idx_i | input | IDX_W | Set index of the access |
| issue_valid_o | output | 1 | One-cycle rebuild issue strobe |
| issue_idx_o | output | IDX_W | Array to rebuild, valid with issue_valid_o |
| pending_o | output | NUM_ARRAYS | Pending bit per array |
| queue_count_o | output | CNT_W | Entries held in the FIFO |
| queue_full_o | output | 1 | FIFO holds QUEUE_DEPTH entries |
| queue_empty_o | output | 1 | FIFO holds no entry |

## Verification
Suppose an in-queue bit is left set by mistake. Every later request for that array is then dropped as a duplicate. The count stops rising one cycle after such a request, and the array never shows up at issue_idx_o again. A stale pending bit appears on pending_o in the cycle after the event that should have cleared it. A counter that is off by one moves issue_valid_o one access early or late. The bench compares every output against a behavioural model on every clock, so each of these faults is reported within one cycle of the first wrong output. Runs with random traffic and periods from 0 to 3 exercise collisions between requests, retries and issues.

// File: rtl/bloom_rebuild_pkg.sv
package bloom_rebuild_pkg;
  typedef enum logic [1:0] {
    ENQ_NONE  = 2'd0,
    ENQ_REQ   = 2'd1,
    ENQ_RETRY = 2'd2
  } enq_src_e;
endpackage

// File: rtl/rbs_fifo.sv
module rbs_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     push_data_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mem_q[g] <= '0;
      else if (push_i && wr_q == PTR_W'(g))       mem_q[g] <= push_data_i;
    end
  end

  p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_no_underflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_count_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/rbs_flags.sv
module rbs_flags
  import bloom_rebuild_pkg::*;
#(
  parameter int unsigned N = 16,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [IDX_W-1:0] req_idx_i,
  input  logic             acc_valid_i,
  input  logic [IDX_W-1:0] acc_idx_i,
  input  logic             full_i,
  input  logic             pop_i,
  input  logic [IDX_W-1:0] pop_idx_i,
  output logic             push_o,
  output logic [IDX_W-1:0] push_idx_o,
  output logic [N-1:0]     pending_o
);
  logic [N-1:0] inq_q, pend_q;
  logic         req_new, req_push, req_park, retry;
  enq_src_e     src;

  assign req_new  = req_valid_i && !inq_q[req_idx_i];
  assign req_push = req_new && !full_i;
  assign req_park = req_new && full_i;
  // a request pushed this cycle owns the slot; retry waits
  assign retry    = acc_valid_i && pend_q[acc_idx_i] && !full_i && !req_push;

  always_comb begin
    src = ENQ_NONE;
    if (req_push)   src = ENQ_REQ;
    else if (retry) src = ENQ_RETRY;
  end

  assign push_o     = (src != ENQ_NONE);
  assign push_idx_o = (src == ENQ_RETRY) ? acc_idx_i : req_idx_i;
  assign pending_o  = pend_q;

  for (genvar g = 0; g < N; g++) begin : g_arr
    logic hit_push, hit_pop, hit_park;
    assign hit_push = push_o && (push_idx_o == IDX_W'(g));
    assign hit_pop  = pop_i && (pop_idx_i == IDX_W'(g));
    assign hit_park = req_park && (req_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        inq_q[g]  <= 1'b0;
        pend_q[g] <= 1'b0;
      end else begin
        if (hit_push)     inq_q[g] <= 1'b1;
        else if (hit_pop) inq_q[g] <= 1'b0;
        if (hit_push)      pend_q[g] <= 1'b0;
        else if (hit_park) pend_q[g] <= 1'b1;
      end
    end
  end

  p_pend_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & inq_q) == '0);
  p_retry_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_push && acc_valid_i && pend_q[acc_idx_i] && acc_idx_i != req_idx_i)
      |=> pend_q[$past(acc_idx_i)]);
  p_dup_block_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && inq_q[req_idx_i] && !pop_i) |=> inq_q[$past(req_idx_i)]);
endmodule

// File: rtl/rbs_pacer.sv
module rbs_pacer #(
  parameter int unsigned PERIOD_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                count_en_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                fire_o
);
  logic [PERIOD_W-1:0] cnt_q;
  logic [PERIOD_W:0]   cnt_next, eff;

  assign eff      = (period_i == '0) ? (PERIOD_W+1)'(1) : {1'b0, period_i};
  assign cnt_next = {1'b0, cnt_q} + (PERIOD_W+1)'(1);
  assign fire_o   = count_en_i && (cnt_next >= eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (fire_o)     cnt_q <= '0;
    else if (count_en_i) cnt_q <= cnt_next[PERIOD_W-1:0];
  end

  p_cnt_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> cnt_q == '0);
  p_cnt_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !count_en_i |=> $stable(cnt_q));
endmodule

// File: rtl/bloom_rebuild_sched.sv
module bloom_rebuild_sched #(
  parameter int unsigned NUM_ARRAYS  = 16,
  parameter int unsigned QUEUE_DEPTH = 4,
  parameter int unsigned PERIOD_W    = 8,
  localparam int unsigned IDX_W = (NUM_ARRAYS > 1) ? $clog2(NUM_ARRAYS) : 1,
  localparam int unsigned CNT_W = $clog2(QUEUE_DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  enable_i,
  input  logic [PERIOD_W-1:0]   period_i,
  input  logic                  req_valid_i,
  input  logic [IDX_W-1:0]      req_idx_i,
  input  logic                  acc_valid_i,
  input  logic [IDX_W-1:0]      acc_idx_i,
  output logic                  issue_valid_o,
  output logic [IDX_W-1:0]      issue_idx_o,
  output logic [NUM_ARRAYS-1:0] pending_o,
  output logic [CNT_W-1:0]      queue_count_o,
  output logic                  queue_full_o,
  output logic                  queue_empty_o
);
  logic             push, fire, count_en;
  logic [IDX_W-1:0] push_idx, head;

  assign count_en = enable_i && acc_valid_i && !queue_empty_o;

  rbs_flags #(.N(NUM_ARRAYS)) u_flags (
    .clk_i, .rst_ni,
    .req_valid_i, .req_idx_i,
    .acc_valid_i, .acc_idx_i,
    .full_i     (queue_full_o),
    .pop_i      (fire),
    .pop_idx_i  (head),
    .push_o     (push),
    .push_idx_o (push_idx),
    .pending_o
  );

  rbs_fifo #(.DEPTH(QUEUE_DEPTH), .W(IDX_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i      (push),
    .push_data_i (push_idx),
    .pop_i       (fire),
    .head_o      (head),
    .count_o     (queue_count_o),
    .full_o      (queue_full_o),
    .empty_o     (queue_empty_o)
  );

  rbs_pacer #(.PERIOD_W(PERIOD_W)) u_pacer (
    .clk_i, .rst_ni,
    .count_en_i (count_en),
    .period_i,
    .fire_o     (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issue_valid_o <= 1'b0;
      issue_idx_o   <= '0;
    end else begin
      issue_valid_o <= fire;
      if (fire) issue_idx_o <= head;
    end
  end

  p_issue_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> $past(enable_i) && $past(acc_valid_i));
  p_period_one_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && acc_valid_i && !queue_empty_o && period_i <= PERIOD_W'(1))
      |=> issue_valid_o);
  p_issue_drains_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && !$past(req_valid_i) && !$past(acc_valid_i && |pending_o))
      |-> queue_count_o == $past(queue_count_o) - 1'b1);
endmodule

// File: tb/sim_bloom_rebuild_sched.sv
`timescale 1ns/1ps
module sim_bloom_rebuild_sched;
  localparam int N = 16, D = 4, PW = 8, IW = 4, CW = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic enable_i = 1'b0, req_valid_i = 1'b0, acc_valid_i = 1'b0;
  logic [PW-1:0] period_i = '0;
  logic [IW-1:0] req_idx_i = '0, acc_idx_i = '0;
  logic issue_valid_o, queue_full_o, queue_empty_o;
  logic [IW-1:0] issue_idx_o;
  logic [N-1:0] pending_o;
  logic [CW-1:0] queue_count_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bloom_rebuild_sched #(.NUM_ARRAYS(N), .QUEUE_DEPTH(D), .PERIOD_W(PW)) u0 (
    .clk_i(clk), .rst_ni, .enable_i, .period_i, .req_valid_i, .req_idx_i,
    .acc_valid_i, .acc_idx_i, .issue_valid_o, .issue_idx_o, .pending_o,
    .queue_count_o, .queue_full_o, .queue_empty_o);

  // behavioural reference
  int m_q[$];
  bit m_inq[N], m_pend[N];
  int m_cnt;
  bit m_iv;
  int m_ii;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q.delete(); m_cnt = 0; m_iv = 0; m_ii = 0;
      foreach (m_inq[i]) begin m_inq[i] = 0; m_pend[i] = 0; end
    end else begin
      int sz, eff, head, pushv;
      bit full, fire, counted, rpush;
      sz = m_q.size(); full = (sz == D);
      eff = (period_i == 0) ? 1 : int'(period_i);
      counted = enable_i && acc_valid_i && sz != 0;
      fire = counted && (m_cnt + 1 >= eff);
      head = (sz != 0) ? m_q[0] : 0;
      pushv = -1; rpush = 0;
      if (req_valid_i && !m_inq[req_idx_i]) begin
        if (!full) begin pushv = req_idx_i; rpush = 1; end
        else m_pend[req_idx_i] = 1;
      end
      if (!rpush && acc_valid_i && m_pend[acc_idx_i] && !full) pushv = acc_idx_i;
      if (fire) begin void'(m_q.pop_front()); m_inq[head] = 0; m_ii = head; end
      m_iv = fire;
      if (pushv >= 0) begin m_q.push_back(pushv); m_inq[pushv] = 1; m_pend[pushv] = 0; end
      if (counted) m_cnt = fire ? 0 : m_cnt + 1;
    end
  end

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", r, act, exp, $time);
    end
  endtask

  function automatic int mpend();
    int v = 0;
    for (int i = 0; i < N; i++) if (m_pend[i]) v |= (1 << i);
    return v;
  endfunction

  task automatic tick();
    @(posedge clk); #3;
    chk("R7 issue_valid", int'(issue_valid_o), int'(m_iv));
    if (m_iv) chk("R7 issue_idx", int'(issue_idx_o), m_ii);
    chk("R4 pending", int'(pending_o), mpend());
    chk("R2 count", int'(queue_count_o), m_q.size());
    chk("R11 full", int'(queue_full_o), int'(m_q.size() == D));
    chk("R11 empty", int'(queue_empty_o), int'(m_q.size() == 0));
  endtask

  task automatic drive(bit rv, int ri, bit av, int ai);
    req_valid_i = rv; req_idx_i = IW'(ri);
    acc_valid_i = av; acc_idx_i = IW'(ai);
    tick();
    req_valid_i = 0; acc_valid_i = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_ni = 1'b1;
    #1;
    chk("R1 count", int'(queue_count_o), 0);
    chk("R1 empty", int'(queue_empty_o), 1);
    chk("R1 full", int'(queue_full_o), 0);
    chk("R1 pending", int'(pending_o), 0);
    chk("R1 issue", int'(issue_valid_o), 0);

    // enable low: queue builds, nothing issues
    period_i = 3;
    drive(1, 2, 0, 0); drive(1, 5, 0, 0);
    drive(1, 5, 0, 0);
    chk("R3 dup ignored", int'(queue_count_o), 2);
    drive(1, 7, 0, 0);
    chk("R2 count", int'(queue_count_o), 3);
    drive(1, 9, 0, 0);
    chk("R11 full", int'(queue_full_o), 1);
    drive(1, 11, 0, 0);
    chk("R4 parked", int'(pending_o[11]), 1);
    chk("R4 count held", int'(queue_count_o), 4);
    for (int i = 0; i < 5; i++) drive(0, 0, 1, 3);
    chk("R9 no issue while disabled", int'(queue_count_o), 4);

    // period 3
    enable_i = 1;
    drive(0, 0, 1, 3); drive(0, 0, 1, 3);
    chk("R7 not yet", int'(issue_valid_o), 0);
    drive(0, 0, 1, 3);
    chk("R7 issue after third", int'(issue_valid_o), 1);
    chk("R7 oldest first", int'(issue_idx_o), 2);
    drive(0, 0, 1, 11);
    chk("R5 retry cleared", int'(pending_o[11]), 0);
    chk("R5 retry queued", int'(queue_count_o), 4);

    // request wins over retry
    period_i = 100;
    drive(1, 12, 0, 0);
    chk("R4 parked 12", int'(pending_o[12]), 1);
    period_i = 1;
    drive(0, 0, 1, 0);
    chk("R7 issue 5", int'(issue_idx_o), 5);
    enable_i = 0;
    drive(1, 13, 1, 12);
    chk("R6 retry waits", int'(pending_o[12]), 1);
    chk("R6 request took slot", int'(queue_count_o), 4);

    // period 0 behaves as 1
    enable_i = 1; period_i = 0;
    drive(0, 0, 1, 0); chk("R8 issue 7", int'(issue_idx_o), 7);
    drive(0, 0, 1, 0); chk("R8 issue 9", int'(issue_idx_o), 9);
    drive(0, 0, 1, 0); chk("R8 issue 11", int'(issue_idx_o), 11);
    drive(0, 0, 1, 0); chk("R8 issue 13", int'(issue_idx_o), 13);
    chk("R8 valid", int'(issue_valid_o), 1);
    chk("R11 empty", int'(queue_empty_o), 1);
    drive(0, 0, 1, 12);
    chk("R5 retry into empty", int'(queue_count_o), 1);
    chk("R7 no count while empty", int'(issue_valid_o), 0);
    drive(1, 7, 0, 0);
    chk("R10 re-request", int'(queue_count_o), 2);

    // random traffic
    for (int i = 0; i < 600; i++) begin
      enable_i = ($urandom_range(0, 9) != 0);
      period_i = PW'($urandom_range(0, 3));
      drive($urandom_range(0, 9) < 4, $urandom_range(0, N - 1),
            $urandom_range(0, 9) < 6, $urandom_range(0, N - 1));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule